// File: doc/BRIEF.md
# Serial configuration write sequencer

This block is the host side of a three-wire, write-only configuration link (serial clock, serial data, active-low select). After reset it sends one frame to each of a fixed set of configuration registers, taking the addresses and values from a parameter table. Only after that first pass has finished does it carry out single-register writes that arrive on a request port. Each frame holds 32 bits and goes out most significant bit first: a constant 12-bit header, a 4-bit register address and a 16-bit value.

The serial clock comes from the system clock through a divider that software sets. Data moves only while the serial clock is low, so the receiver samples stable data on each rising edge. A calibration-busy input stops any new frame from starting. A frame that is already on the wire finishes, and the burst then closes. When another frame is ready at a frame boundary, it follows at once and select stays low. Between bursts, select stays high for at least one full serial clock period.

The request port is valid/ready. The requester raises `req_valid` with an address and a value, and must hold all three steady until `req_ready` is high at a clock edge. `req_ready` is a single-cycle acknowledge that comes only once the frame for that request has fully left the block. A request can therefore wait for a long time, during the initial pass or a calibration, and that wait is the only back-pressure the port has.

Top module: `cfgwire_seq`

## Requirements
- R1: While reset is asserted, `ser_sel_n` is 1, `ser_clk` is 0, `ser_dat` is 0, `init_done` is 0 and `req_ready` is 0.
- R2: Each frame is 32 bits, sent most significant bit first. Bits 31:20 hold the header 0x001, bits 19:16 hold the address (bit 19 goes first) and bits 15:0 hold the value.
- R3: `ser_dat` changes only while `ser_clk` is low. It never changes between two system clocks in which `ser_clk` is high.
- R4: Each high phase of `ser_clk` lasts exactly `half_div`+1 system clocks. Each low phase lasts at least that long.
- R5: After reset, the first frames sent are the NUM_INIT table entries, in index order (entry 0 first). Every request frame comes after them.
- R6: `init_done` rises after the last table frame completes and then stays high until reset.
- R7: `req_ready` is high for one cycle, only while `req_valid` is high, and only after every bit of that request's frame has been clocked out. A request raised during the initial pass waits and is not lost.
- R8: If another frame is ready when a frame ends, it follows in the same burst and `ser_sel_n` stays low between the two frames.
- R9: While `cal_busy` is high, no frame starts. A frame already in progress completes, and the burst then closes with `ser_sel_n` high.
- R10: Before a burst starts, `ser_sel_n` has been high for at least 2×(`half_div`+1) system clocks. This applies to the first burst after reset and to every later burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| half_div | input | DIV_W | Serial clock half period, minus one, in system clocks. Change only between bursts |
| cal_busy | input | 1 | High while calibration runs. Stops new frames |
| req_valid | input | 1 | Single-write request present |
| req_ready | output | 1 | One-cycle acknowledge once the request's frame has completed |
| req_addr | input | 4 | Register address of the request |
| req_data | input | 16 | Value of the request |
| init_done | output | 1 | Initial pass finished |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_dat | output | 1 | Serial data |
| ser_sel_n | output | 1 | Active-low select |

## Verification
The serial clock high phase is due exactly `half_div`+1 system clocks after each rising edge. The first select fall after reset, or after calibration clears, is due no earlier than 2×(`half_div`+1)+1 clocks later. `req_ready` rises in the same cycle as the falling edge that ends the request's last bit, and `init_done` follows one cycle after the last table frame. The bench does not count cycles to find frames. It decodes each frame by sampling data at every serial clock rise, and compares the result in order against a queue that the stimulus tasks fill. Edge timing is measured by counting sampled high cycles between clock and select transitions. All sampling happens on the falling system clock edge, half a period after the registers update.

// File: rtl/cws_pkg.sv
package cws_pkg;
  localparam int ADDR_W  = 4;
  localparam int DATA_W  = 16;
  localparam int HDR_W   = 12;
  localparam int FRAME_W = HDR_W + ADDR_W + DATA_W;
  localparam int CNT_W   = $clog2(FRAME_W);
  localparam logic [HDR_W-1:0] HDR_PAT = 12'h001;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_BOUND = 2'd2
  } seq_st_t;

  function automatic logic [FRAME_W-1:0] mk_frame(input logic [ADDR_W-1:0] a,
                                                  input logic [DATA_W-1:0] d);
    return {HDR_PAT, a, d};
  endfunction
endpackage

// File: rtl/cws_tick.sv
// Half-period strobe for the serial clock.
module cws_tick #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  input  logic [W-1:0] limit,
  output logic         tick
);
  logic [W-1:0] cnt;

  // >= keeps the strobe alive if the limit is lowered while counting
  assign tick = !restart && (cnt >= limit);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt <= '0;
    else if (restart || tick) cnt <= '0;
    else                      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/cws_shreg.sv
// Frame shift register, MSB leaves first.
module cws_shreg #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [W-1:0] din,
  output logic         msb
);
  logic [W-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= din;
    else if (shift) q <= {q[W-2:0], 1'b0};
  end

  assign msb = q[W-1];
endmodule

// File: rtl/cws_init_tab.sv
// Initial-pass table, entry i taken from the i-th slice of the parameters.
module cws_init_tab
  import cws_pkg::*;
#(
  parameter int N     = 6,
  parameter int IDX_W = 3,
  parameter logic [N*ADDR_W-1:0] ADDRS = '0,
  parameter logic [N*DATA_W-1:0] VALS  = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] data
);
  logic [ADDR_W-1:0] a_arr [N];
  logic [DATA_W-1:0] d_arr [N];

  for (genvar i = 0; i < N; i++) begin : g_ent
    assign a_arr[i] = ADDRS[i*ADDR_W +: ADDR_W];
    assign d_arr[i] = VALS[i*DATA_W +: DATA_W];
  end

  always_comb begin
    addr = '0;
    data = '0;
    for (int j = 0; j < N; j++) begin
      if (idx == IDX_W'(j)) begin
        addr = a_arr[j];
        data = d_arr[j];
      end
    end
  end
endmodule

// File: rtl/cfgwire_seq.sv
module cfgwire_seq
  import cws_pkg::*;
#(
  parameter int NUM_INIT = 6,
  parameter int DIV_W    = 8,
  parameter logic [NUM_INIT*ADDR_W-1:0] INIT_ADDR =
    {4'hF, 4'hE, 4'hD, 4'h3, 4'h2, 4'h1},
  parameter logic [NUM_INIT*DATA_W-1:0] INIT_DATA =
    {16'hFFFF, 16'h4000, 16'h0F0F, 16'h807F, 16'h1234, 16'hA5C3}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DIV_W-1:0]  half_div,
  input  logic              cal_busy,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_data,
  output logic              init_done,
  output logic              ser_clk,
  output logic              ser_dat,
  output logic              ser_sel_n
);
  localparam int IDX_W = $clog2(NUM_INIT + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_W - 1);
  localparam logic [1:0] GAP_TICKS = 2'd2;

  seq_st_t          st;
  logic             sclk_q, sel_n_q, from_req;
  logic [CNT_W-1:0] bit_cnt;
  logic [1:0]       gap_cnt;
  logic [IDX_W-1:0] idx;

  logic              tick, restart, load, shift, done;
  logic              have_init, can_start, next_is_req;
  logic [ADDR_W-1:0] tab_addr;
  logic [DATA_W-1:0] tab_data;
  logic [FRAME_W-1:0] next_frame;

  cws_init_tab #(
    .N(NUM_INIT), .IDX_W(IDX_W), .ADDRS(INIT_ADDR), .VALS(INIT_DATA)
  ) u_tab (
    .idx(idx), .addr(tab_addr), .data(tab_data)
  );

  cws_tick #(.W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .restart(restart), .limit(half_div), .tick(tick)
  );

  cws_shreg #(.W(FRAME_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(shift),
    .din(next_frame), .msb(ser_dat)
  );

  // table entries win over requests until the table is exhausted
  assign have_init   = (idx != IDX_W'(NUM_INIT));
  assign next_is_req = !have_init;
  assign can_start   = (have_init || req_valid) && !cal_busy;
  assign next_frame  = have_init ? mk_frame(tab_addr, tab_data)
                                 : mk_frame(req_addr, req_data);

  assign load = can_start && ((st == ST_IDLE && gap_cnt == GAP_TICKS) ||
                              (st == ST_BOUND));
  assign restart = load || (st == ST_BOUND);

  // falling edge of the serial clock: either next bit or end of frame
  assign shift = (st == ST_SHIFT) && tick && sclk_q && (bit_cnt != '0);
  assign done  = (st == ST_SHIFT) && tick && sclk_q && (bit_cnt == '0);

  assign req_ready = done && from_req;
  assign init_done = !have_init;
  assign ser_clk   = sclk_q;
  assign ser_sel_n = sel_n_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      sclk_q   <= 1'b0;
      sel_n_q  <= 1'b1;
      from_req <= 1'b0;
      bit_cnt  <= '0;
      gap_cnt  <= '0;
      idx      <= '0;
    end else begin
      if (done && !from_req) idx <= idx + 1'b1;
      unique case (st)
        ST_IDLE: begin
          if (load) begin
            st       <= ST_SHIFT;
            sel_n_q  <= 1'b0;
            bit_cnt  <= LAST_BIT;
            from_req <= next_is_req;
          end else if (tick && gap_cnt != GAP_TICKS) begin
            gap_cnt <= gap_cnt + 1'b1;
          end
        end
        ST_SHIFT: begin
          if (tick) begin
            if (!sclk_q) begin
              sclk_q <= 1'b1;
            end else begin
              sclk_q <= 1'b0;
              if (bit_cnt != '0) bit_cnt <= bit_cnt - 1'b1;
              else               st      <= ST_BOUND;
            end
          end
        end
        ST_BOUND: begin
          if (load) begin
            st       <= ST_SHIFT;
            bit_cnt  <= LAST_BIT;
            from_req <= next_is_req;
          end else begin
            st      <= ST_IDLE;
            sel_n_q <= 1'b1;
            gap_cnt <= '0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/cfgwire_seq_chk.sv
module cfgwire_seq_chk #(
  parameter int DIV_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DIV_W-1:0] half_div,
  input logic             cal_busy,
  input logic             req_valid,
  input logic             req_ready,
  input logic             init_done,
  input logic             ser_clk,
  input logic             ser_dat,
  input logic             ser_sel_n
);
  localparam int HW = DIV_W + 1;
  localparam int GW = DIV_W + 3;

  logic [HW-1:0] hi_cnt;
  logic [GW-1:0] sel_cnt;
  logic [HW-1:0] half_len;
  logic [GW-1:0] gap_min;

  assign half_len = HW'(half_div) + 1'b1;
  assign gap_min  = GW'(half_len) << 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_cnt  <= '0;
      sel_cnt <= '0;
    end else begin
      hi_cnt  <= ser_clk ? hi_cnt + 1'b1 : '0;
      if (!ser_sel_n)     sel_cnt <= '0;
      else if (~&sel_cnt) sel_cnt <= sel_cnt + 1'b1;
    end
  end

  // R3
  dat_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ser_clk && $past(ser_clk)) |-> $stable(ser_dat));

  // R4
  clk_high_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_clk) |-> (hi_cnt == half_len));

  // R6
  init_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> init_done);

  // R7
  ack_needs_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> req_valid);

  // R7
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R9
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_sel_n) |-> !$past(cal_busy));

  // R10
  sel_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ser_sel_n) |-> (sel_cnt >= gap_min));
endmodule

bind cfgwire_seq cfgwire_seq_chk #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .half_div(half_div), .cal_busy(cal_busy),
  .req_valid(req_valid), .req_ready(req_ready), .init_done(init_done),
  .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_sel_n(ser_sel_n)
);

// File: tb/cfgwire_seq_test.sv
module cfgwire_seq_test;
  localparam int NI = 6;
  localparam int DW = 8;
  localparam logic [NI*4-1:0]  T_ADDR = {4'hF, 4'hE, 4'hD, 4'h3, 4'h2, 4'h1};
  localparam logic [NI*16-1:0] T_DATA =
    {16'hFFFF, 16'h4000, 16'h0F0F, 16'h807F, 16'h1234, 16'hA5C3};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [DW-1:0] half_div;
  logic cal_busy, req_valid, req_ready, init_done;
  logic [3:0]  req_addr;
  logic [15:0] req_data;
  logic ser_clk, ser_dat, ser_sel_n;

  always #2 clk = ~clk;

  cfgwire_seq #(.NUM_INIT(NI), .DIV_W(DW), .INIT_ADDR(T_ADDR), .INIT_DATA(T_DATA)) uut (
    .clk(clk), .rst_n(rst_n), .half_div(half_div), .cal_busy(cal_busy),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_data(req_data), .init_done(init_done), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ser_sel_n(ser_sel_n)
  );

  int n_chk = 0, n_bad = 0;
  int frames_rx = 0, sel_rises = 0, sel_falls = 0, cur_half = 1;
  logic [31:0] exp_q[$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // monitor: decode frames at serial clock rises, time edges
  logic p_clk = 1'b0, p_sel = 1'b1, p_dat = 1'b0;
  logic [31:0] sh = '0, e_fr;
  int nb = 0, hi = 0, selhi = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ser_sel_n && ser_clk && !p_clk) begin
        sh = {sh[30:0], ser_dat};
        nb++;
        if (nb == 32) begin
          nb = 0;
          frames_rx++;
          chk(sh[31:20] == 12'h001, "R2 header", 32'(sh[31:20]), 32'h001);
          if (exp_q.size() == 0) chk(1'b0, "R5 unexpected frame", sh, 32'h0);
          else begin
            e_fr = exp_q.pop_front();
            chk(sh == e_fr, "R5 frame order/content", sh, e_fr);
          end
        end
      end
      if (ser_clk && p_clk && ser_dat != p_dat)
        chk(1'b0, "R3 data moved with clock high", 32'(ser_dat), 32'(p_dat));
      if (ser_clk) hi++;
      if (!ser_clk && p_clk) begin
        chk(hi == cur_half + 1, "R4 high phase length", hi, cur_half + 1);
        hi = 0;
      end
      if (ser_sel_n) selhi++;
      if (!ser_sel_n && p_sel) begin
        sel_falls++;
        chk(selhi >= 2 * (cur_half + 1), "R10 select idle gap", selhi, 2 * (cur_half + 1));
        selhi = 0;
      end
      if (ser_sel_n && !p_sel) begin
        sel_rises++;
        chk(nb == 0, "R9 burst closed mid-frame", nb, 0);
      end
      p_clk = ser_clk;
      p_sel = ser_sel_n;
      p_dat = ser_dat;
    end
  end

  task automatic put_req(input logic [3:0] a, input logic [15:0] d);
    exp_q.push_back({12'h001, a, d});
    req_addr  = a;
    req_data  = d;
    req_valid = 1'b1;
  endtask

  // returns in the cycle after the handshake edge
  task automatic wait_ack(input string tag, input int lim);
    bit got = 1'b0;
    for (int i = 0; i < lim && !got; i++) begin
      @(negedge clk);
      if (req_ready) got = 1'b1;
    end
    chk(got, tag, 32'(got), 32'h1);
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    int f0, r0, nack;
    half_div = DW'(1);
    cal_busy = 1'b1;
    req_valid = 1'b0;
    req_addr = '0;
    req_data = '0;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk(ser_sel_n == 1'b1, "R1 select", 32'(ser_sel_n), 32'h1);
    chk(ser_clk == 1'b0, "R1 clock", 32'(ser_clk), 32'h0);
    chk(ser_dat == 1'b0, "R1 data", 32'(ser_dat), 32'h0);
    chk(init_done == 1'b0, "R1 init_done", 32'(init_done), 32'h0);
    chk(req_ready == 1'b0, "R1 ready", 32'(req_ready), 32'h0);

    for (int i = 0; i < NI; i++)
      exp_q.push_back({12'h001, T_ADDR[i*4 +: 4], T_DATA[i*16 +: 16]});
    rst_n = 1'b1;

    // R9: calibration running from reset holds off the initial pass
    repeat (60) @(negedge clk);
    chk(sel_falls == 0, "R9 no burst while busy", sel_falls, 0);
    chk(init_done == 1'b0, "R6 not done before pass", 32'(init_done), 32'h0);
    cal_busy = 1'b0;

    // R5/R7: request raised during the initial pass waits behind it
    repeat (20) @(negedge clk);
    chk(sel_falls == 1 && init_done == 1'b0, "R5 pass under way", sel_falls, 1);
    put_req(4'h5, 16'hBEEF);
    wait_ack("R7 ack of queued request", 5000);
    req_valid = 1'b0;
    chk(frames_rx == NI + 1, "R7 frame complete at ack", frames_rx, NI + 1);
    chk(init_done == 1'b1, "R6 done after pass", 32'(init_done), 32'h1);
    chk(sel_rises == 0, "R8 single burst for pass and request", sel_rises, 0);

    // R8: two back-to-back requests share one burst
    repeat (40) @(negedge clk);
    r0 = sel_rises;
    put_req(4'hA, 16'h0001);
    wait_ack("R7 ack A", 5000);
    put_req(4'hB, 16'h8000);
    wait_ack("R7 ack B", 5000);
    req_valid = 1'b0;
    chk(sel_rises == r0, "R8 select held between frames", sel_rises, r0);
    repeat (10) @(negedge clk);
    chk(sel_rises == r0 + 1, "R8 burst closes after last", sel_rises, r0 + 1);

    // R4: slower divider
    repeat (20) @(negedge clk);
    half_div = DW'(3);
    cur_half = 3;
    repeat (20) @(negedge clk);
    put_req(4'h3, 16'h5A5A);
    wait_ack("R4 ack with slow clock", 5000);
    req_valid = 1'b0;

    // R9: request pending during calibration is held
    repeat (20) @(negedge clk);
    cal_busy = 1'b1;
    f0 = sel_falls;
    r0 = frames_rx;
    put_req(4'h7, 16'hC3C3);
    nack = 0;
    repeat (300) begin
      @(negedge clk);
      if (req_ready) nack++;
    end
    chk(nack == 0, "R9 no ack while busy", nack, 0);
    chk(sel_falls == f0 && frames_rx == r0, "R9 no frame while busy", sel_falls, f0);
    cal_busy = 1'b0;
    wait_ack("R9 ack after busy clears", 5000);
    req_valid = 1'b0;

    // R9: calibration raised mid-frame lets the frame finish, then blocks
    repeat (30) @(negedge clk);
    put_req(4'h8, 16'h0F00);
    for (int i = 0; i < 200 && ser_sel_n; i++) @(negedge clk);
    repeat (10) @(negedge clk);
    cal_busy = 1'b1;
    wait_ack("R9 frame in flight completes", 5000);
    put_req(4'h9, 16'h00F0);
    repeat (5) @(negedge clk);
    chk(ser_sel_n == 1'b1, "R9 burst closed under busy", 32'(ser_sel_n), 32'h1);
    f0 = sel_falls;
    repeat (200) @(negedge clk);
    chk(sel_falls == f0, "R9 second request held", sel_falls, f0);
    cal_busy = 1'b0;
    wait_ack("R7 ack after release", 5000);
    req_valid = 1'b0;

    repeat (50) @(negedge clk);
    chk(exp_q.size() == 0, "R2 all expected frames seen", exp_q.size(), 0);
    chk(init_done == 1'b1, "R6 stays high", 32'(init_done), 32'h1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule